// File: doc/BRIEF.md
# Two-Way Fetch Thread Selector with Shared Slot Budget

This block sits in the front end of a simultaneous multithreaded core. It decides which hardware threads fetch in the coming cycle and how many instructions each of them may bring in. Each thread supplies three inputs. The first is its current instruction-queue occupancy. The second is a demand count: how many instructions it could usefully accept. The third is a flag that says whether it may fetch at all. A thread with a cache miss or a stall drops that flag.

The block ranks the eligible threads by occupancy and picks up to two of them, the least-filled first. If two threads have equal occupancy, the lower thread index wins. The first pick receives its demand, clipped to the per-cycle slot budget. The second pick receives its demand clipped to whatever budget the first pick left. The grants therefore follow each thread's need rather than a fixed even split. The result is registered, so a decision appears one cycle after its inputs are sampled.

Top module: `fetch_pick_top`

## Requirements
- R1: At most two threads are reported per cycle, and when both picks are valid their thread indices differ.
- R2: Pick 0 is the eligible thread with the smallest occupancy; among equal occupancies the lowest thread index is chosen.
- R3: Pick 1 is the eligible thread with the smallest occupancy once pick 0 is excluded, with ties going to the lower index; its occupancy is never below that of pick 0.
- R4: The grant of pick 0 equals its demand, limited to the slot budget (8 by default).
- R5: The grant of pick 1 equals its demand, limited to the budget minus the grant of pick 0, so the two grants together never exceed the budget.
- R6: A thread whose eligibility flag is 0 is never picked. With exactly one eligible thread only pick 0 is valid. With none, neither pick is valid. An invalid pick reports index 0 and grant 0.
- R7: A demand value above the budget (9 to 15 on the 4-bit input) is treated as equal to the budget. A demand of 0 still lets the thread be picked, with a grant of 0.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high reset drives both valid flags, both indices and both grants to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| occ_i | input | NT*OCC_W (28) | Queue occupancy per thread; thread t occupies bits [t*OCC_W +: OCC_W] |
| demand_i | input | NT*DEM_W (16) | Demand per thread; thread t occupies bits [t*DEM_W +: DEM_W] |
| elig_i | input | NT (4) | Bit t set means thread t may fetch |
| pick0_vld | output | 1 | First pick valid |
| pick0_id | output | TID_W (2) | Thread index of the first pick |
| pick0_cnt | output | CNT_W (4) | Instructions granted to the first pick |
| pick1_vld | output | 1 | Second pick valid |
| pick1_id | output | TID_W (2) | Thread index of the second pick |
| pick1_cnt | output | CNT_W (4) | Instructions granted to the second pick |

## Verification
The bench builds the block with its defaults: four threads, 7-bit occupancy, 4-bit demand and a budget of 8. With these values the demand input can exceed the budget, so the clipping path is reachable. Random occupancies drawn from a narrow range force frequent ties, which exercises the lower-index rule for both picks. Every eligibility pattern, including zero or one eligible thread, occurs within a few hundred random cycles. Directed cases cover maximum occupancy, zero demand, budgets that run out exactly, and a reset applied while a selection is in flight.

// File: rtl/fetch_pick_pkg.sv
`timescale 1ns/1ps
package fetch_pick_pkg;

    localparam int unsigned NT_DEF     = 4;
    localparam int unsigned OCC_W_DEF  = 7;
    localparam int unsigned DEM_W_DEF  = 4;
    localparam int unsigned BUDGET_DEF = 8;

    // smaller of two unsigned values
    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/fetch_min_picker.sv
`timescale 1ns/1ps
// Finds the candidate with the lowest occupancy; strict compare keeps the lower index on ties.
module fetch_min_picker #(
    parameter int unsigned NT    = 4,
    parameter int unsigned OCC_W = 7,
    localparam int unsigned TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT*OCC_W-1:0] occ,
    input  logic [NT-1:0]       cand,
    output logic                found,
    output logic [TID_W-1:0]    idx
);
    logic [OCC_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < int'(NT); i++) begin
            if (cand[i] && (!found || (occ[i*OCC_W +: OCC_W] < best))) begin
                found = 1'b1;
                idx   = TID_W'(i);
                best  = occ[i*OCC_W +: OCC_W];
            end
        end
    end
endmodule

// File: rtl/fetch_grant_split.sv
`timescale 1ns/1ps
// Divides the per-cycle slot budget between the first and second pick.
module fetch_grant_split #(
    parameter int unsigned DEM_W  = 4,
    parameter int unsigned BUDGET = 8,
    localparam int unsigned CNT_W = $clog2(BUDGET + 1)
) (
    input  logic             use0,
    input  logic             use1,
    input  logic [DEM_W-1:0] dem0,
    input  logic [DEM_W-1:0] dem1,
    output logic [CNT_W-1:0] grant0,
    output logic [CNT_W-1:0] grant1
);
    import fetch_pick_pkg::*;

    int unsigned g0, left;

    always_comb begin
        g0     = use0 ? umin(int'(dem0), BUDGET) : 0;
        left   = BUDGET - g0;
        grant0 = CNT_W'(g0);
        grant1 = use1 ? CNT_W'(umin(int'(dem1), left)) : '0;
    end
endmodule

// File: rtl/fetch_pick_top.sv
`timescale 1ns/1ps
module fetch_pick_top #(
    parameter int unsigned NT     = fetch_pick_pkg::NT_DEF,
    parameter int unsigned OCC_W  = fetch_pick_pkg::OCC_W_DEF,
    parameter int unsigned DEM_W  = fetch_pick_pkg::DEM_W_DEF,
    parameter int unsigned BUDGET = fetch_pick_pkg::BUDGET_DEF,
    localparam int unsigned TID_W = (NT > 1) ? $clog2(NT) : 1,
    localparam int unsigned CNT_W = $clog2(BUDGET + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NT*OCC_W-1:0]  occ_i,
    input  logic [NT*DEM_W-1:0]  demand_i,
    input  logic [NT-1:0]        elig_i,
    output logic                 pick0_vld,
    output logic [TID_W-1:0]     pick0_id,
    output logic [CNT_W-1:0]     pick0_cnt,
    output logic                 pick1_vld,
    output logic [TID_W-1:0]     pick1_id,
    output logic [CNT_W-1:0]     pick1_cnt
);
    typedef struct packed {
        logic             v0;
        logic [TID_W-1:0] id0;
        logic [CNT_W-1:0] c0;
        logic             v1;
        logic [TID_W-1:0] id1;
        logic [CNT_W-1:0] c1;
    } pick_st_t;

    pick_st_t st_d, st_q;

    logic             f0_found, f1_found;
    logic [TID_W-1:0] f0_idx, f1_idx;
    logic [NT-1:0]    rest_cand;
    logic [DEM_W-1:0] dem0_sel, dem1_sel;
    logic [CNT_W-1:0] g0, g1;

    fetch_min_picker #(.NT(NT), .OCC_W(OCC_W)) u_first (
        .occ(occ_i), .cand(elig_i), .found(f0_found), .idx(f0_idx)
    );

    always_comb begin
        rest_cand = elig_i;
        if (f0_found) rest_cand[f0_idx] = 1'b0;
    end

    fetch_min_picker #(.NT(NT), .OCC_W(OCC_W)) u_second (
        .occ(occ_i), .cand(rest_cand), .found(f1_found), .idx(f1_idx)
    );

    assign dem0_sel = demand_i[f0_idx*DEM_W +: DEM_W];
    assign dem1_sel = demand_i[f1_idx*DEM_W +: DEM_W];

    fetch_grant_split #(.DEM_W(DEM_W), .BUDGET(BUDGET)) u_split (
        .use0(f0_found), .use1(f1_found),
        .dem0(dem0_sel), .dem1(dem1_sel),
        .grant0(g0), .grant1(g1)
    );

    always_comb begin
        st_d     = '0;
        st_d.v0  = f0_found;
        st_d.id0 = f0_found ? f0_idx : '0;
        st_d.c0  = g0;
        st_d.v1  = f1_found;
        st_d.id1 = f1_found ? f1_idx : '0;
        st_d.c1  = g1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pick0_vld = st_q.v0;
    assign pick0_id  = st_q.id0;
    assign pick0_cnt = st_q.c0;
    assign pick1_vld = st_q.v1;
    assign pick1_id  = st_q.id1;
    assign pick1_cnt = st_q.c1;
endmodule

// File: rtl/fetch_pick_chk.sv
`timescale 1ns/1ps
module fetch_pick_chk #(
    parameter int unsigned NT     = 4,
    parameter int unsigned OCC_W  = 7,
    parameter int unsigned DEM_W  = 4,
    parameter int unsigned BUDGET = 8,
    localparam int unsigned TID_W = (NT > 1) ? $clog2(NT) : 1,
    localparam int unsigned CNT_W = $clog2(BUDGET + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [NT*OCC_W-1:0] occ_i,
    input logic [NT*DEM_W-1:0] demand_i,
    input logic [NT-1:0]       elig_i,
    input logic                pick0_vld,
    input logic [TID_W-1:0]    pick0_id,
    input logic [CNT_W-1:0]    pick0_cnt,
    input logic                pick1_vld,
    input logic [TID_W-1:0]    pick1_id,
    input logic [CNT_W-1:0]    pick1_cnt
);
    logic [NT*OCC_W-1:0] occ_p;
    logic [NT*DEM_W-1:0] dem_p;
    logic [NT-1:0]       elig_p;
    logic                seen;

    always_ff @(posedge clk) begin
        occ_p  <= occ_i;
        dem_p  <= demand_i;
        elig_p <= elig_i;
        seen   <= !rst;
    end

    logic [CNT_W:0] sum_w;
    assign sum_w = {1'b0, pick0_cnt} + {1'b0, pick1_cnt};

    p_pair_distinct_r1: assert property (@(posedge clk) disable iff (rst)
        (seen && pick0_vld && pick1_vld) |-> (pick0_id != pick1_id));

    p_first_elig_r2: assert property (@(posedge clk) disable iff (rst)
        (seen && pick0_vld) |-> elig_p[pick0_id]);

    p_second_elig_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && pick1_vld) |-> elig_p[pick1_id]);

    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        (seen && pick0_vld && pick1_vld) |->
        (occ_p[pick0_id*OCC_W +: OCC_W] <= occ_p[pick1_id*OCC_W +: OCC_W]));

    p_grant0_le_dem_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && pick0_vld) |-> (DEM_W'(pick0_cnt) <= dem_p[pick0_id*DEM_W +: DEM_W]));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        seen |-> (sum_w <= (CNT_W+1)'(BUDGET)));

    p_second_needs_first_r6: assert property (@(posedge clk) disable iff (rst)
        pick1_vld |-> pick0_vld);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!pick1_vld) |-> (pick1_cnt == '0));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!pick0_vld && !pick1_vld && pick0_cnt == '0 && pick1_cnt == '0));
endmodule

bind fetch_pick_top fetch_pick_chk #(
    .NT(NT), .OCC_W(OCC_W), .DEM_W(DEM_W), .BUDGET(BUDGET)
) u_chk (
    .clk(clk), .rst(rst), .occ_i(occ_i), .demand_i(demand_i), .elig_i(elig_i),
    .pick0_vld(pick0_vld), .pick0_id(pick0_id), .pick0_cnt(pick0_cnt),
    .pick1_vld(pick1_vld), .pick1_id(pick1_id), .pick1_cnt(pick1_cnt)
);

// File: tb/fetch_pick_top_test.sv
`timescale 1ns/1ps
module fetch_pick_top_test;
    localparam int NT = 4, OCC_W = 7, DEM_W = 4, BUDGET = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT*OCC_W-1:0] occ_i = '0;
    logic [NT*DEM_W-1:0] demand_i = '0;
    logic [NT-1:0]       elig_i = '0;
    logic       pick0_vld, pick1_vld;
    logic [1:0] pick0_id, pick1_id;
    logic [3:0] pick0_cnt, pick1_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // expected result of the last applied vector
    int e_v0, e_id0, e_c0, e_v1, e_id1, e_c1;

    always #5 clk = ~clk;

    fetch_pick_top uut (
        .clk(clk), .rst(rst), .occ_i(occ_i), .demand_i(demand_i), .elig_i(elig_i),
        .pick0_vld(pick0_vld), .pick0_id(pick0_id), .pick0_cnt(pick0_cnt),
        .pick1_vld(pick1_vld), .pick1_id(pick1_id), .pick1_cnt(pick1_cnt)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int occ_of(input int t);
        return int'(occ_i[t*OCC_W +: OCC_W]);
    endfunction

    function automatic int dem_of(input int t);
        int d = int'(demand_i[t*DEM_W +: DEM_W]);
        return (d > BUDGET) ? BUDGET : d;
    endfunction

    task automatic compute_exp();
        e_v0 = 0; e_id0 = 0; e_c0 = 0; e_v1 = 0; e_id1 = 0; e_c1 = 0;
        for (int t = 0; t < NT; t++)
            if (elig_i[t] && (!e_v0 || occ_of(t) < occ_of(e_id0))) begin e_v0 = 1; e_id0 = t; end
        for (int t = 0; t < NT; t++)
            if (elig_i[t] && !(e_v0 && t == e_id0) && (!e_v1 || occ_of(t) < occ_of(e_id1))) begin
                e_v1 = 1; e_id1 = t;
            end
        if (e_v0) e_c0 = dem_of(e_id0);
        if (e_v1) e_c1 = (dem_of(e_id1) < BUDGET - e_c0) ? dem_of(e_id1) : BUDGET - e_c0;
    endtask

    task automatic compare_all();
        chk("R2", "pick0_vld", int'(pick0_vld), e_v0);
        chk("R2", "pick0_id",  int'(pick0_id),  e_id0);
        chk("R4", "pick0_cnt", int'(pick0_cnt), e_c0);
        chk("R6", "pick1_vld", int'(pick1_vld), e_v1);
        chk("R3", "pick1_id",  int'(pick1_id),  e_id1);
        chk("R5", "pick1_cnt", int'(pick1_cnt), e_c1);
        if (pick0_vld && pick1_vld) chk("R1", "distinct", int'(pick0_id != pick1_id), 1);
    endtask

    // called at a falling edge; result is checked at the following falling edge
    task automatic apply(input logic [NT*OCC_W-1:0] o, input logic [NT*DEM_W-1:0] d,
                         input logic [NT-1:0] e);
        occ_i = o; demand_i = d; elig_i = e;
        #1;
        // R8: new inputs must not be visible before the next rising edge
        chk("R8", "hold pick0_cnt", int'(pick0_cnt), e_c0);
        chk("R8", "hold pick0_id",  int'(pick0_id),  e_id0);
        compute_exp();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [NT*OCC_W-1:0] pk_occ(input int a, input int b, input int c, input int d);
        return {OCC_W'(d), OCC_W'(c), OCC_W'(b), OCC_W'(a)};
    endfunction

    function automatic logic [NT*DEM_W-1:0] pk_dem(input int a, input int b, input int c, input int d);
        return {DEM_W'(d), DEM_W'(c), DEM_W'(b), DEM_W'(a)};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        s = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", "reset pick0_vld", int'(pick0_vld), 0);
        chk("R8", "reset pick1_vld", int'(pick1_vld), 0);
        chk("R8", "reset pick0_cnt", int'(pick0_cnt), 0);
        chk("R8", "reset pick1_cnt", int'(pick1_cnt), 0);
        rst = 1'b0;

        // R2/R3: all occupancies tie -> threads 0 and 1
        apply(pk_occ(5, 5, 5, 5), pk_dem(3, 4, 2, 2), 4'b1111);
        // R5: budget runs out exactly
        apply(pk_occ(9, 2, 7, 1), pk_dem(1, 5, 8, 3), 4'b1111);
        // R7: demand 15 clipped; second gets zero
        apply(pk_occ(10, 20, 0, 30), pk_dem(15, 6, 15, 2), 4'b1111);
        chk("R7", "clip grant0", int'(pick0_cnt), 8);
        // R6: single eligible thread
        apply(pk_occ(1, 2, 3, 0), pk_dem(4, 4, 4, 4), 4'b0100);
        chk("R6", "single pick1_vld", int'(pick1_vld), 0);
        // R6: none eligible
        apply(pk_occ(1, 2, 3, 0), pk_dem(4, 4, 4, 4), 4'b0000);
        chk("R6", "none pick0_vld", int'(pick0_vld), 0);
        // R6: lowest occupancy thread ineligible
        apply(pk_occ(127, 0, 127, 126), pk_dem(2, 7, 9, 1), 4'b1101);
        // R7: zero demand still picked
        apply(pk_occ(4, 3, 127, 127), pk_dem(0, 0, 5, 5), 4'b0011);
        chk("R7", "zero demand vld", int'(pick0_vld), 1);
        // R3: tie for second place, lower index wins
        apply(pk_occ(8, 3, 8, 8), pk_dem(2, 2, 2, 2), 4'b1111);

        for (int n = 0; n < 3000; n++) begin
            logic [NT*OCC_W-1:0] o;
            logic [NT*DEM_W-1:0] d;
            for (int t = 0; t < NT; t++) begin
                o[t*OCC_W +: OCC_W] = (n % 2 == 0) ? OCC_W'($urandom % 4) : OCC_W'($urandom);
                d[t*DEM_W +: DEM_W] = DEM_W'($urandom);
            end
            apply(o, d, NT'($urandom));
        end

        // R8: reset while a selection is active
        apply(pk_occ(1, 2, 3, 4), pk_dem(3, 3, 3, 3), 4'b1111);
        rst = 1'b1;
        @(negedge clk);
        chk("R8", "mid reset pick0_vld", int'(pick0_vld), 0);
        chk("R8", "mid reset pick1_cnt", int'(pick1_cnt), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule